// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a single programmable countdown timer behind a small synchronous register port. A clock-enable input supplies the raw tick. A selectable prescaler thins that tick by 1, 16 or 256 before it reaches the counter. The counter is 16 or 32 bits wide and decrements once per prescaled step while the timer is enabled. When it reaches zero, a raw event flag is set. An interrupt line follows that flag, gated by an enable bit.

Three counting behaviours are available. In periodic mode the count reloads from a stored reload value and continues. In one-shot mode the count parks at zero and the timer disables itself. Free-running mode applies when neither of the other two is chosen: the count wraps at the full range of the selected width and ignores the stored value.

There are two ways to change the reload value. A write to the primary load register also restarts the count at once. A write to the background load register only takes effect at the next reload.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, timer stopped, 16-bit, free-running), and the count, the stored reload value and the raw flag all read 0. `irq_o` is low.
- R2: Byte offsets decode as follows: 0x00 primary load, 0x04 count, 0x08 control, 0x0C event clear, 0x10 raw status, 0x14 masked status, 0x18 background load. Both load offsets read back the stored reload value. Offset 0x04 reads the live count. Control reads in bits [7:0] with bit 4 always 0. Status registers read in bit 0. Any other offset reads 0.
- R3: A primary load write stores the value and sets the count at once to the effective reload value. In periodic or one-shot mode that is the stored value truncated to the selected width. A background load write stores the value and leaves the count unchanged.
- R4: A control write whose enable bit (bit 7) is 1 sets the count to the effective reload value computed from the new control value. A control write with bit 7 clear leaves the count unchanged.
- R5: The count decrements by one on each prescaled step while enabled. While disabled, ticks have no effect.
- R6: Control bits [3:2] select the prescale: 0 gives a step every tick, 1 every 16 ticks, 2 every 256 ticks, and 3 every tick. A step falls on the last tick of each group, counted from the most recent control or primary load write.
- R7: Periodic mode is selected by control bit 6. A step taken with the count at 1 or 0 sets the raw flag and reloads the effective reload value, so the period is that many steps.
- R8: One-shot mode is selected by control bit 0. A step taken with the count at 1 or 0 sets the raw flag, leaves the count at 0 and clears control bit 7.
- R9: With control bits 0 and 6 both clear, the effective reload value is 0xFFFF when control bit 1 is 0 and 0xFFFFFFFF when it is 1, whatever the stored value.
- R10: `irq_o` is the raw flag ANDed with control bit 5. Masked status reads 0 while bit 5 is clear.
- R11: Writing any value to the event clear offset clears the raw flag. An expiry in the same cycle wins, and the flag stays set.
- R12: Writes to the count offset and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Raw count enable, one tick per high cycle |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is an expiry that lands in the same clock cycle as a write to the event clear register. This needs a tick and a clear write in one cycle while the count sits at 1. The bench gets there by arming a periodic timer with a reload of 1 and then driving the clear write and the tick together for one cycle. The second hard state is the 16-bit free-running wrap, which takes 65535 steps. The bench reaches it by holding the tick high continuously for that whole stretch.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // control field layout, MSB first; bit order is software-visible
  typedef struct packed {
    logic       run;       // 7
    logic       periodic;  // 6
    logic       irq_en;    // 5
    logic       rsvd;      // 4
    logic [1:0] psc;       // 3:2
    logic       wide;      // 1
    logic       oneshot;   // 0
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'h20;

  localparam int OFF_LOAD  = 'h00;
  localparam int OFF_COUNT = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_CLR   = 'h0C;
  localparam int OFF_RAW   = 'h10;
  localparam int OFF_MASK  = 'h14;
  localparam int OFF_BGLD  = 'h18;

  localparam logic [1:0] PSC_DIV_A = 2'd1;
  localparam logic [1:0] PSC_DIV_B = 2'd2;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SHIFT_A = 4,
  parameter int SHIFT_B = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  import timer_pkg::*;

  localparam int PW = SHIFT_B;
  localparam logic [PW-1:0] TERM_A = PW'((1 << SHIFT_A) - 1);
  localparam logic [PW-1:0] TERM_B = PW'((1 << SHIFT_B) - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] term;

  always_comb begin
    unique case (sel_i)
      PSC_DIV_A: term = TERM_A;
      PSC_DIV_B: term = TERM_B;
      default:   term = '0;
    endcase
  end

  assign step_o = run_i && tick_i && (pre_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || restart_i) pre_q <= '0;
    else if (tick_i)            pre_q <= step_o ? '0 : pre_q + 1'b1;
  end

  a_r5_no_step_when_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
  a_r6_step_after_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && run_i) |=> (pre_q == '0));

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             oneshot_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = step_i && !load_i && (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= oneshot_i ? '0 : reload_i;
    else if (step_i)   cnt_q <= cnt_q - 1'b1;
  end

  a_r3_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !oneshot_i) |=> (cnt_q == $past(reload_i)));
  a_r8_oneshot_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && oneshot_i) |=> (cnt_q == '0));

endmodule

// File: rtl/timer_regs.sv
module timer_regs #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               expire_i,
  input  logic [DATA_W-1:0]  cnt_i,
  output timer_pkg::ctrl_t   ctrl_o,
  output logic [DATA_W-1:0]  reload_o,
  output logic               cnt_load_o,
  output logic [DATA_W-1:0]  cnt_load_val_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  import timer_pkg::*;

  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  ctrl_t             ctrl_q, ctrl_wv;
  logic [DATA_W-1:0] load_q;
  logic              raw_q;
  logic              wr, rd;
  logic              wr_load, wr_ctrl, wr_clr, wr_bgld;

  function automatic logic [DATA_W-1:0] eff_reload(ctrl_t c, logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    m = c.wide ? '1 : NARROW_MASK;
    return (!c.periodic && !c.oneshot) ? m : (v & m);
  endfunction

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wr_load = wr && (addr_i == ADDR_W'(OFF_LOAD));
  assign wr_ctrl = wr && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_clr  = wr && (addr_i == ADDR_W'(OFF_CLR));
  assign wr_bgld = wr && (addr_i == ADDR_W'(OFF_BGLD));

  always_comb begin
    ctrl_wv      = ctrl_t'(wdata_i[7:0]);
    ctrl_wv.rsvd = 1'b0;
  end

  assign cnt_load_o     = wr_load || (wr_ctrl && ctrl_wv.run);
  assign cnt_load_val_o = wr_load ? eff_reload(ctrl_q, wdata_i) : eff_reload(ctrl_wv, load_q);
  assign reload_o       = eff_reload(ctrl_q, load_q);
  assign ctrl_o         = ctrl_q;
  assign irq_o          = raw_q && ctrl_q.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_ctrl)                          ctrl_q     <= ctrl_wv;
      else if (expire_i && ctrl_q.oneshot) ctrl_q.run <= 1'b0;
      if (wr_load || wr_bgld)               load_q     <= wdata_i;
      if (expire_i)                         raw_q      <= 1'b1;
      else if (wr_clr)                      raw_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) begin
      unique case (addr_i)
        ADDR_W'(OFF_LOAD), ADDR_W'(OFF_BGLD): rdata_o <= load_q;
        ADDR_W'(OFF_COUNT): rdata_o <= cnt_i;
        ADDR_W'(OFF_CTRL):  rdata_o <= DATA_W'(ctrl_q);
        ADDR_W'(OFF_RAW):   rdata_o <= DATA_W'(raw_q);
        ADDR_W'(OFF_MASK):  rdata_o <= DATA_W'(raw_q && ctrl_q.irq_en);
        default:            rdata_o <= '0;
      endcase
    end
  end

  a_r11_expiry_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> raw_q);
  a_r11_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !expire_i) |=> !raw_q);
  a_r8_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.run);
  a_r10_masked_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.irq_en |-> !irq_o);
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.rsvd);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SHIFT_A  = 4,
  parameter int SHIFT_B  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import timer_pkg::*;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, cnt, cnt_load_val;
  logic              cnt_load, step, expire;

  timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .expire_i      (expire),
    .cnt_i         (cnt),
    .ctrl_o        (ctrl),
    .reload_o      (reload),
    .cnt_load_o    (cnt_load),
    .cnt_load_val_o(cnt_load_val),
    .rdata_o, .irq_o
  );

  timer_prescaler #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_psc (
    .clk_i, .rst_ni,
    .run_i    (ctrl.run),
    .restart_i(cnt_load),
    .tick_i,
    .sel_i    (ctrl.psc),
    .step_o   (step)
  );

  timer_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i    (step),
    .load_i    (cnt_load),
    .load_val_i(cnt_load_val),
    .reload_i  (reload),
    .oneshot_i (ctrl.oneshot),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  a_r12_count_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_COUNT) && !step) |=> $stable(cnt));

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic        clk = 0, rst_ni = 0, tick = 0, req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  interval_timer u0 (.clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_chk(string r, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    chk(r, rdata, exp);
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    rst_ni = 1;
    rd_chk("R1 ctrl", 8'h08, 32'h20);
    rd_chk("R1 count", 8'h04, 0);
    rd_chk("R1 load", 8'h00, 0);
    rd_chk("R1 raw", 8'h10, 0);

    // R2/R3 readback and truncation
    wr(8'h08, 32'h62);
    wr(8'h00, 32'h12345678);
    rd_chk("R3 count after load 32b", 8'h04, 32'h12345678);
    rd_chk("R2 load readback", 8'h00, 32'h12345678);
    rd_chk("R2 bg load alias", 8'h18, 32'h12345678);
    rd_chk("R2 ctrl readback", 8'h08, 32'h62);
    wr(8'h08, 32'h60);
    wr(8'h00, 32'hABCD1234);
    rd_chk("R3 count truncated 16b", 8'h04, 32'h1234);
    rd_chk("R3 load keeps full", 8'h00, 32'hABCD1234);

    // R9 free-running reload value
    wr(8'h08, 32'h22);
    wr(8'h00, 5);
    rd_chk("R9 free 32b reload", 8'h04, 32'hFFFFFFFF);
    wr(8'h08, 32'h20);
    wr(8'h00, 7);
    rd_chk("R9 free 16b reload", 8'h04, 32'hFFFF);

    // R12 ignored writes, R2 unmapped and reserved bit
    wr(8'h04, 32'h55);
    rd_chk("R12 count write ignored", 8'h04, 32'hFFFF);
    wr(8'h1C, 32'hFF);
    rd_chk("R12 ctrl after unmapped wr", 8'h08, 32'h20);
    rd_chk("R12 load after unmapped wr", 8'h00, 7);
    rd_chk("R2 unmapped read", 8'h1C, 0);
    wr(8'h08, 32'h3F);
    rd_chk("R2 rsvd bit reads 0", 8'h08, 32'h2F);
    wr(8'h08, 32'h20);

    // R5 disabled ignores ticks
    ticks(10);
    rd_chk("R5 disabled holds", 8'h04, 32'hFFFF);

    // R7/R4 periodic sweep
    for (int l = 1; l <= 6; l++) begin
      wr(8'h08, 32'h62); wr(8'h00, l); wr(8'h0C, 0); wr(8'h08, 32'hE2);
      rd_chk("R4 enable reloads", 8'h04, l);
      for (int k = 1; k <= l; k++) begin
        ticks(1);
        if (k < l) begin
          rd_chk("R5 decrement", 8'h04, l - k);
          rd_chk("R7 no early flag", 8'h10, 0);
        end else begin
          rd_chk("R7 reload at zero", 8'h04, l);
          rd_chk("R7 flag at zero", 8'h10, 1);
          chk("R10 irq high", {31'b0, irq}, 1);
        end
      end
      wr(8'h0C, 0);
      rd_chk("R11 clear", 8'h10, 0);
      chk("R10 irq low after clear", {31'b0, irq}, 0);
    end

    // R4 disable write keeps count
    wr(8'h08, 32'h62);
    wr(8'h00, 9);
    wr(8'h08, 32'h60);
    rd_chk("R4 disabled ctrl write keeps count", 8'h04, 9);

    // R6 prescale sweep
    for (int p = 0; p < 4; p++) begin
      int dv;
      dv = (p == 1) ? 16 : (p == 2) ? 256 : 1;
      wr(8'h08, 32'h62); wr(8'h00, 3); wr(8'h0C, 0);
      wr(8'h08, 32'hE2 | (p << 2));
      if (dv > 1) begin
        ticks(dv - 1);
        rd_chk("R6 no step before group end", 8'h04, 3);
      end
      ticks(1);
      rd_chk("R6 step at group end", 8'h04, 2);
      ticks(2 * dv);
      rd_chk("R6 reload after 3 steps", 8'h04, 3);
      rd_chk("R6 flag after 3 steps", 8'h10, 1);
      wr(8'h0C, 0);
    end

    // R8 one-shot
    wr(8'h08, 32'h23); wr(8'h00, 3); wr(8'h0C, 0); wr(8'h08, 32'hA3);
    ticks(2);
    rd_chk("R8 counting", 8'h04, 1);
    rd_chk("R8 no flag yet", 8'h10, 0);
    ticks(1);
    rd_chk("R8 parks at zero", 8'h04, 0);
    rd_chk("R8 flag", 8'h10, 1);
    rd_chk("R8 run bit cleared", 8'h08, 32'h23);
    ticks(5);
    rd_chk("R8 stays zero", 8'h04, 0);

    // R10 masking
    wr(8'h08, 32'h03);
    chk("R10 irq masked", {31'b0, irq}, 0);
    rd_chk("R10 masked status 0", 8'h14, 0);
    rd_chk("R10 raw still set", 8'h10, 1);
    wr(8'h08, 32'h23);
    chk("R10 irq unmasked", {31'b0, irq}, 1);
    rd_chk("R10 masked status 1", 8'h14, 1);
    wr(8'h0C, 32'hDEAD);
    rd_chk("R11 clear any value", 8'h10, 0);

    // R3 background load
    wr(8'h08, 32'h62); wr(8'h00, 4); wr(8'h08, 32'hE2);
    ticks(1);
    rd_chk("R3 before bg load", 8'h04, 3);
    wr(8'h18, 2);
    rd_chk("R3 bg load keeps count", 8'h04, 3);
    rd_chk("R3 bg load stored", 8'h00, 2);
    ticks(2);
    rd_chk("R3 old count continues", 8'h04, 1);
    ticks(1);
    rd_chk("R3 next reload uses bg", 8'h04, 2);
    rd_chk("R7 flag with bg reload", 8'h10, 1);

    // R11 expiry and clear in the same cycle
    wr(8'h08, 32'h62); wr(8'h00, 1); wr(8'h0C, 0); wr(8'h08, 32'hE2);
    @(negedge clk); req = 1; we = 1; addr = 8'h0C; wdata = 0; tick = 1;
    @(negedge clk); req = 0; we = 0; tick = 0;
    rd_chk("R11 expiry beats clear", 8'h10, 1);
    wr(8'h0C, 0);

    // R9 16-bit free-running wrap
    wr(8'h08, 32'hA0);
    rd_chk("R9 enable loads 0xFFFF", 8'h04, 32'hFFFF);
    ticks(1);
    rd_chk("R9 first step", 8'h04, 32'hFFFE);
    ticks(65533);
    rd_chk("R9 near wrap", 8'h04, 1);
    rd_chk("R9 no flag before wrap", 8'h10, 0);
    ticks(1);
    rd_chk("R9 wraps to full range", 8'h04, 32'hFFFF);
    rd_chk("R9 flag on wrap", 8'h10, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule